// File: doc/BRIEF.md
# VCO Band-Select Timing Sequencer

This block times the automatic oscillator band search that follows a write to the frequency word of a synthesizer. A start pulse, raised by the register-0 write, opens a selection window. The window is measured in periods of a slow band-select clock, which is made by dividing the phase-detector clock by a 10-bit divisor. The divisor is built from two separate register fields. While the window is open the block reports itself busy and hides the raw lock indication, because lock is not meaningful while the band is still being chosen.

When the window closes, an optional output gate can keep the RF outputs muted until a qualified lock is seen. An optional delay requires lock to stay up for a programmed number of phase-detector cycles with no gap before the outputs are released, which keeps a flickering lock from toggling the outputs. A temperature-aware mode stretches the window to a longer period count. The analog tuning work is done elsewhere; this block only supplies its timing.

Top module: `vco_band_sel_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o is 0, lock_valid_o equals lock_raw_i, and rf_mute_o equals mute_en_i.
- R2: The divisor is {bs_hi_i, bs_lo_i}: bs_hi_i forms bits 9:8 and bs_lo_i forms bits 7:0. With bs_hi_i=1 and bs_lo_i=0 the divisor is 256.
- R3: A divisor code of 0 acts as a divisor of 1, so the window still closes after the normal period count.
- R4: After a clock edge that samples start_i=1 with temp_mode_i=0, busy_o stays 1 for exactly PERIODS x divisor clock cycles (PERIODS defaults to 10) and then falls. The divisor and the mode are taken at the start edge; later changes to those inputs do not alter an open window.
- R5: With temp_mode_i=1 at the start edge, the window lasts TEMP_PERIODS x divisor cycles (TEMP_PERIODS defaults to 100).
- R6: A start pulse that arrives while the window is open restarts it: busy_o then stays 1 for a full window counted from the new start edge.
- R7: lock_valid_o is lock_raw_i while busy_o is 0, and is 0 while busy_o is 1.
- R8: With mute_en_i=0, rf_mute_o is 0 in every cycle.
- R9: With mute_en_i=1 and mute_dly_en_i=0, rf_mute_o stays 1 until a clock edge that samples lock_valid_o=1. From that edge on it is 0 until the next start.
- R10: With mute_dly_en_i=1, the gate opens only at the edge where lock_valid_o has been sampled 1 on MUTE_DLY_CYCLES consecutive edges (default 16). Any edge that samples it 0 restarts the count.
- R11: Every start pulse closes the gate again, so rf_mute_o returns to mute_en_i until the gate re-qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase-detector clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse from the frequency-word write |
| bs_lo_i | input | 8 | Low divisor field (divisor bits 7:0) |
| bs_hi_i | input | 2 | High divisor field (divisor bits 9:8) |
| temp_mode_i | input | 1 | Selects the long temperature-aware window |
| mute_en_i | input | 1 | Mute RF outputs until lock qualifies |
| mute_dly_en_i | input | 1 | Require continuous lock for the delay count before unmuting |
| lock_raw_i | input | 1 | Unqualified lock indication |
| busy_o | output | 1 | Band selection in progress |
| lock_valid_o | output | 1 | Lock indication with the selection window masked out |
| rf_mute_o | output | 1 | RF output mute |

## Verification
Directed windows use divisors 3, 0, 256, 1023 and a temperature-mode case. Each window length separates off-by-one errors in the prescaler, a wrong field join, a missing zero clamp and a wrong period count from one another. Restart, re-mute and a lock waveform with a single-cycle drop inside the delay count show whether the gate counts consecutive cycles or total cycles. A long seeded random run then mixes start pulses, divisor changes in mid-window, lock toggling and mode bits. It is compared cycle by cycle with a bench model that tracks remaining busy cycles as a plain countdown, not as a divider and a period counter.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int BS_LO_W = 8;
  localparam int BS_HI_W = 2;
  localparam int BS_W    = BS_LO_W + BS_HI_W;

  typedef logic [BS_W-1:0] bs_t;

  typedef enum logic [1:0] {
    GATE_SHUT = 2'd0,
    GATE_QUAL = 2'd1,
    GATE_OPEN = 2'd2
  } gate_state_e;

  // Join the two register fields into one divisor code.
  function automatic bs_t bs_join(input logic [BS_LO_W-1:0] lo,
                                  input logic [BS_HI_W-1:0] hi);
    return {hi, lo};
  endfunction

  // The reserved code 0 behaves as a divide-by-one.
  function automatic bs_t bs_effective(input bs_t raw);
    return (raw == '0) ? bs_t'(1) : raw;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vbs_divider.sv
module vbs_divider
  import vbs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  input  logic run_i,
  input  bs_t  div_i,
  output logic tick_o
);
  bs_t div_q;
  bs_t pre_q;
  logic at_end;

  assign at_end = (pre_q == (div_q - bs_t'(1)));
  assign tick_o = run_i && at_end;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      div_q <= bs_t'(1);
      pre_q <= '0;
    end else if (start_i) begin
      div_q <= div_i;
      pre_q <= '0;
    end else if (run_i) begin
      pre_q <= at_end ? '0 : (pre_q + bs_t'(1));
    end
  end
endmodule

// File: rtl/vbs_window.sv
module vbs_window
  import vbs_pkg::*;
#(
  parameter int PERIODS      = 10,
  parameter int TEMP_PERIODS = 100
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  input  logic temp_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXP  = max_int(PERIODS, TEMP_PERIODS);
  localparam int CNT_W = $clog2(MAXP + 1);

  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] lim_q;
  logic             busy_q;
  logic             last_period;

  assign last_period = (per_q == (lim_q - CNT_W'(1)));
  assign done_o      = busy_q && tick_i && last_period;
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      per_q  <= '0;
      lim_q  <= CNT_W'(PERIODS);
      busy_q <= 1'b0;
    end else if (start_i) begin
      per_q  <= '0;
      lim_q  <= temp_i ? CNT_W'(TEMP_PERIODS) : CNT_W'(PERIODS);
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (last_period) begin
        busy_q <= 1'b0;
        per_q  <= '0;
      end else begin
        per_q <= per_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vbs_mute_gate.sv
module vbs_mute_gate
  import vbs_pkg::*;
#(
  parameter int DLY_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic start_i,
  input  logic lock_ok_i,
  input  logic dly_en_i,
  output logic open_o,
  output logic release_o
);
  localparam int DLY_W = $clog2(DLY_CYCLES + 1);

  gate_state_e      st_q;
  logic [DLY_W-1:0] cnt_q;
  logic             qualified;

  assign qualified = !dly_en_i || (cnt_q == DLY_W'(DLY_CYCLES - 1));
  assign release_o = (st_q != GATE_OPEN) && !start_i && lock_ok_i && qualified;
  assign open_o    = (st_q == GATE_OPEN);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      st_q  <= GATE_SHUT;
      cnt_q <= '0;
    end else if (start_i) begin
      st_q  <= GATE_SHUT;
      cnt_q <= '0;
    end else if (st_q != GATE_OPEN) begin
      if (!lock_ok_i) begin
        st_q  <= GATE_SHUT;
        cnt_q <= '0;
      end else if (release_o) begin
        st_q  <= GATE_OPEN;
        cnt_q <= '0;
      end else begin
        st_q  <= GATE_QUAL;
        cnt_q <= cnt_q + DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/vco_band_sel_seq.sv
module vco_band_sel_seq
  import vbs_pkg::*;
#(
  parameter int PERIODS         = 10,
  parameter int TEMP_PERIODS    = 100,
  parameter int MUTE_DLY_CYCLES = 16
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               start_i,
  input  logic [BS_LO_W-1:0] bs_lo_i,
  input  logic [BS_HI_W-1:0] bs_hi_i,
  input  logic               temp_mode_i,
  input  logic               mute_en_i,
  input  logic               mute_dly_en_i,
  input  logic               lock_raw_i,
  output logic               busy_o,
  output logic               lock_valid_o,
  output logic               rf_mute_o
);
  // Named internal events, visible to the bound checker.
  bs_t  eff_div;
  logic band_tick;
  logic window_busy;
  logic window_done;
  logic gate_open;
  logic gate_release;

  assign eff_div = bs_effective(bs_join(bs_lo_i, bs_hi_i));

  vbs_divider u_div (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .start_i (start_i),
    .run_i   (window_busy),
    .div_i   (eff_div),
    .tick_o  (band_tick)
  );

  vbs_window #(
    .PERIODS      (PERIODS),
    .TEMP_PERIODS (TEMP_PERIODS)
  ) u_win (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .start_i (start_i),
    .temp_i  (temp_mode_i),
    .tick_i  (band_tick),
    .busy_o  (window_busy),
    .done_o  (window_done)
  );

  assign lock_valid_o = lock_raw_i && !window_busy;

  vbs_mute_gate #(
    .DLY_CYCLES (MUTE_DLY_CYCLES)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .start_i   (start_i),
    .lock_ok_i (lock_valid_o),
    .dly_en_i  (mute_dly_en_i),
    .open_o    (gate_open),
    .release_o (gate_release)
  );

  assign busy_o    = window_busy;
  assign rf_mute_o = mute_en_i && !gate_open;
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker (
  input logic clk_i,
  input logic rst_n_i,
  input logic start_i,
  input logic band_tick,
  input logic window_done,
  input logic busy_o,
  input logic lock_valid_o,
  input logic mute_en_i,
  input logic rf_mute_o,
  input logic gate_release,
  input logic gate_open
);
  assert_tick_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    band_tick |-> busy_o);

  assert_done_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (window_done && !start_i) |=> !busy_o);

  assert_busy_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_o && !window_done && !start_i) |=> busy_o);

  assert_start_opens_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_i |=> busy_o);

  assert_lock_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    busy_o |-> !lock_valid_o);

  assert_no_mute_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !mute_en_i |-> !rf_mute_o);

  assert_release_on_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    gate_release |-> lock_valid_o);

  assert_start_remutes_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_i |=> !gate_open);
endmodule

bind vco_band_sel_seq vbs_checker chk_i (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .start_i      (start_i),
  .band_tick    (band_tick),
  .window_done  (window_done),
  .busy_o       (busy_o),
  .lock_valid_o (lock_valid_o),
  .mute_en_i    (mute_en_i),
  .rf_mute_o    (rf_mute_o),
  .gate_release (gate_release),
  .gate_open    (gate_open)
);

// File: tb/vco_band_sel_seq_tb_top.sv
`timescale 1ns/1ps
module vco_band_sel_seq_tb_top;
  localparam int P_NORM = 10;
  localparam int P_TEMP = 100;
  localparam int DLY    = 16;
  localparam int WD_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_r = 1'b0;
  logic [7:0] lo_r = 8'd3;
  logic [1:0] hi_r = 2'd0;
  logic temp_r = 1'b0;
  logic men_r = 1'b1;
  logic den_r = 1'b0;
  logic lock_r = 1'b0;
  logic busy_w, lv_w, mute_w;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R4";

  always #10 clk = ~clk;

  vco_band_sel_seq dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .start_i(start_r),
    .bs_lo_i(lo_r), .bs_hi_i(hi_r), .temp_mode_i(temp_r),
    .mute_en_i(men_r), .mute_dly_en_i(den_r), .lock_raw_i(lock_r),
    .busy_o(busy_w), .lock_valid_o(lv_w), .rf_mute_o(mute_w)
  );

  // Window length in clock cycles, restated from R2..R5.
  function automatic int win_cycles(input logic [7:0] lo, input logic [1:0] hi, input logic t);
    int v;
    v = int'(hi) * 256 + int'(lo);
    if (v < 1) v = 1;
    return (t ? P_TEMP : P_NORM) * v;
  endfunction

  // Reference model: busy countdown plus consecutive-lock run length.
  int m_rem = 0;
  int m_run = 0;
  bit m_open = 0;
  bit m_lv;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_run = 0; m_open = 0;
    end else begin
      m_lv = lock_r && (m_rem == 0);
      if (start_r) begin
        m_rem = win_cycles(lo_r, hi_r, temp_r);
        m_open = 0; m_run = 0;
      end else begin
        if (m_rem > 0) m_rem--;
        if (!m_open) begin
          if (m_lv) begin
            m_run++;
            if (!den_r || m_run >= DLY) m_open = 1;
          end else m_run = 0;
        end
      end
    end
  end

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic eb;
    eb = (m_rem > 0);
    cmp(cur_tag, "busy", busy_w, eb);
    cmp("R7", "lock_valid", lv_w, lock_r && !eb);
    if (!men_r) cmp("R8", "mute", mute_w, 1'b0);
    else if (den_r) cmp("R10", "mute", mute_w, !m_open);
    else cmp("R9", "mute", mute_w, !m_open);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      start_r = 1'b0;
    end
  endtask

  task automatic fire();
    @(negedge clk);
    check_all();
    start_r = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h0BAD5EED));
    lock_r = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    cmp("R1", "busy in reset", busy_w, 1'b0);
    cmp("R1", "lock_valid in reset", lv_w, 1'b1);
    cmp("R1", "mute in reset", mute_w, 1'b1);
    lock_r = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", "busy after reset", busy_w, 1'b0);
    cmp("R1", "mute after reset", mute_w, 1'b1);

    // R4: divisor 3, lock held high through window; bs changed mid-window
    cur_tag = "R4"; lock_r = 1'b1; lo_r = 8'd3;
    fire(); step(5); lo_r = 8'd40; temp_r = 1'b1; step(40);
    temp_r = 1'b0;

    // R3: reserved code 0
    cur_tag = "R3"; lo_r = 8'd0; hi_r = 2'd0;
    fire(); step(14);

    // R2: high field only -> 256
    cur_tag = "R2"; lo_r = 8'd0; hi_r = 2'd1;
    fire(); step(2570);
    hi_r = 2'd0;

    // R5: temperature mode, divisor 2
    cur_tag = "R5"; temp_r = 1'b1; lo_r = 8'd2;
    fire(); step(210);
    temp_r = 1'b0;

    // R6: restart mid-window
    cur_tag = "R6"; lo_r = 8'd4;
    fire(); step(25); fire(); step(45);

    // R8: mute disabled with lock toggling across a window
    cur_tag = "R8"; men_r = 1'b0; lo_r = 8'd1;
    fire();
    for (int i = 0; i < 30; i++) begin step(1); lock_r = ~lock_r; end
    men_r = 1'b1;

    // R10: delay qualification with a one-cycle lock drop
    cur_tag = "R10"; den_r = 1'b1; lock_r = 1'b0; lo_r = 8'd1;
    fire(); step(12);
    lock_r = 1'b1; step(5);
    lock_r = 1'b0; step(1);
    lock_r = 1'b1; step(10);
    cmp("R10", "still muted before count ends", mute_w, 1'b1);
    step(12);
    cmp("R10", "released after continuous lock", mute_w, 1'b0);

    // R11: start after release re-mutes
    cur_tag = "R11"; den_r = 1'b0;
    fire(); step(1);
    cmp("R11", "re-muted after start", mute_w, 1'b1);
    step(15);

    // R4: largest divisor
    cur_tag = "R4"; lo_r = 8'd255; hi_r = 2'd3;
    fire(); step(10240);
    hi_r = 2'd0;

    // Random mix
    cur_tag = "R4";
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      check_all();
      start_r = ($urandom % 60) == 0;
      if (($urandom % 8) == 0) lock_r = ~lock_r;
      lo_r = 8'($urandom % 12);
      hi_r = (($urandom % 40) == 0) ? 2'd1 : 2'd0;
      temp_r = ($urandom % 8) == 0;
      if (($urandom % 400) == 0) men_r = ~men_r;
      if (($urandom % 300) == 0) den_r = ~den_r;
    end
    start_r = 1'b0;
    step(3000);

    summary();
    $finish;
  end
endmodule